// File: doc/BRIEF.md
# Two-Wire Slave Command Decoder for a Dual-Channel Potentiometer

This block is the serial front end of a two-channel digital potentiometer. It sits on an I2C-compatible two-wire bus as a slave. The bus clock and data lines are oversampled on a fast system clock. The block detects start and stop conditions, shifts bytes in and out, and pulls the data line low through an open-drain output enable. The 7-bit slave address is a fixed five-bit prefix followed by two strap bits taken from input pins.

A write transaction carries the address byte, then one instruction byte, then any number of data bytes. The instruction byte picks the channel and carries the midscale, shutdown and two logic-output flags. Each data byte that follows updates the channel chosen by that instruction. The block reports each completed instruction byte and each completed data byte to the register block as a one-cycle strobe with its fields. A read transaction has no instruction byte. It returns the register of the channel chosen by the most recent instruction, and it repeats that value for as long as the master acknowledges. A repeated start right after an instruction byte lets a master pick a channel and then read it.

The controller is one state machine:
- States: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_INSTR`, `ST_INSTR_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_RD_BYTE`, `ST_RD_ACK`.
- Every transition except those caused by a start or stop condition happens on a synchronized SCL falling edge.
- From any state, a stop condition goes to `ST_IDLE` and a start condition goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` after eight bits if the address matches, and to `ST_IDLE` if it does not.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` for a read and to `ST_INSTR` for a write.
- `ST_INSTR` goes to `ST_INSTR_ACK` after eight bits, and `ST_INSTR_ACK` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK` after eight bits, and `ST_DATA_ACK` returns to `ST_DATA`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` on a master acknowledge and to `ST_IDLE` on a not-acknowledge.

Top module: `pot_i2c_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), no strobe is active and the selected channel is 0. A read issued before any instruction returns `chan0_val`.
- R2: The slave acknowledges an address byte only when its bits 7..1 (MSB first) equal 0,1,0,1,1,`strap[1]`,`strap[0]`. Bit 0 is R/W, with 1 meaning read. A slave that is not addressed drives nothing and emits no strobe until the next start.
- R3: In a write, the byte after the address is acknowledged and produces one `instr_stb` pulse with the fields channel = bit 7, midscale = bit 6, shutdown = bit 5, O1 = bit 4, O2 = bit 3. Bits 2..0 have no effect.
- R4: Every later byte of the same write is acknowledged and produces one `data_stb` pulse, with `data_val` equal to the byte and `data_sel` equal to the channel from that transaction's instruction.
- R5: In a read, the byte right after the address acknowledge is the selected channel's register (`chan1_val` if the last instruction's bit 7 was 1, otherwise `chan0_val`), sent MSB first.
- R6: A master acknowledge after a read byte makes the slave send the same register again. A not-acknowledge releases SDA, and the slave drives nothing until a start.
- R7: A repeated start directly after an instruction byte, followed by a read address, returns the register of the channel that instruction selected, with no data strobe.
- R8: A start or stop condition in the middle of a byte aborts the transaction with no strobe for the partial byte. A start begins a new address phase.
- R9: The slave changes its SDA drive only after a synchronized SCL falling edge and never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap | input | 2 | Pin-strapped low address bits |
| chan0_val | input | 8 | Current register value of channel 0 |
| chan1_val | input | 8 | Current register value of channel 1 |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| instr_stb | output | 1 | One-cycle pulse when an instruction byte completes |
| instr_sel | output | 1 | Channel selected by the last instruction |
| instr_mid | output | 1 | Midscale flag of the last instruction |
| instr_shdn | output | 1 | Shutdown flag of the last instruction |
| instr_o1 | output | 1 | O1 logic-output value of the last instruction |
| instr_o2 | output | 1 | O2 logic-output value of the last instruction |
| data_stb | output | 1 | One-cycle pulse when a data byte completes |
| data_val | output | 8 | Value of the last completed data byte |
| data_sel | output | 1 | Channel that the data byte targets |

## Verification
A wrong bit counter or a wrong state shows up on the bus within one byte time. The acknowledge appears in the wrong clock slot or is missing, or a strobe arrives too early, too late or for a partial byte. A wrong held channel select shows up only at the next read or data strobe, as a returned value or `data_sel` from the other channel. For that reason the bench reads back after every kind of channel change. A slave that changes SDA while SCL is high is caught in the same cycle by the checker. A slave that fails to release SDA after a not-acknowledge reads back as zero bits on the following clocked byte.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } state_t;

endpackage

// File: rtl/pot_i2c_sync.sv
// Multi-stage synchronizer per line, with the previous synchronized value
// kept for edge detection. Lines reset to the idle-high bus level.
module pot_i2c_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] now,
    output logic [LINES-1:0] prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], raw[g]};
        end
        assign now[g]  = chain[STAGES-1];
        assign prev[g] = chain[STAGES];
    end
endmodule

// File: rtl/pot_i2c_slave.sv
module pot_i2c_slave
    import pot_i2c_pkg::*;
#(
    parameter int               PREFIX_W    = 5,
    parameter logic [PREFIX_W-1:0] PREFIX   = 5'b01011,
    parameter int               STRAP_W     = 2,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  chan0_val,
    input  logic [BYTE_W-1:0]  chan1_val,
    output logic               sda_oe,
    output logic               instr_stb,
    output logic               instr_sel,
    output logic               instr_mid,
    output logic               instr_shdn,
    output logic               instr_o1,
    output logic               instr_o2,
    output logic               data_stb,
    output logic [BYTE_W-1:0]  data_val,
    output logic               data_sel
);
    // Address field width must equal BYTE_W-1 (7-bit addressing).
    localparam int ADDR_W = PREFIX_W + STRAP_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic [1:0] line_now, line_prev;
    logic scl_q, sda_q, scl_d, sda_d;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    pot_i2c_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .now  (line_now),
        .prev (line_prev)
    );

    assign scl_q     = line_now[0];
    assign sda_q     = line_now[1];
    assign scl_d     = line_prev[0];
    assign sda_d     = line_prev[1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign bus_start = scl_q & scl_d & sda_d & ~sda_q;
    assign bus_stop  = scl_q & scl_d & ~sda_d & sda_q;

    state_t            state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] tx_src;
    logic              rw_q;
    logic              master_ack;
    logic              byte_done;
    logic              addr_hit;

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[BYTE_W-1 -: ADDR_W] == {PREFIX, strap});
    assign tx_src    = instr_sel ? chan1_val : chan0_val;

    // Next-state logic
    always_comb begin
        nxt = state;
        if (bus_stop) begin
            nxt = ST_IDLE;
        end else if (bus_start) begin
            nxt = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  nxt = rw_q ? ST_RD_BYTE : ST_INSTR;
                ST_INSTR:     if (byte_done) nxt = ST_INSTR_ACK;
                ST_INSTR_ACK: nxt = ST_DATA;
                ST_DATA:      if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK:  nxt = ST_DATA;
                ST_RD_BYTE:   if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:    nxt = master_ack ? ST_RD_BYTE : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            tx         <= '0;
            rw_q       <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
            instr_stb  <= 1'b0;
            instr_sel  <= 1'b0;
            instr_mid  <= 1'b0;
            instr_shdn <= 1'b0;
            instr_o1   <= 1'b0;
            instr_o2   <= 1'b0;
            data_stb   <= 1'b0;
            data_val   <= '0;
            data_sel   <= 1'b0;
        end else begin
            instr_stb <= 1'b0;
            data_stb  <= 1'b0;
            if (bus_start || bus_stop) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                if (scl_rise) begin
                    if (state inside {ST_ADDR, ST_INSTR, ST_DATA, ST_RD_BYTE}) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= {shreg[BYTE_W-2:0], sda_q};
                    end
                    if (state == ST_RD_ACK) master_ack <= ~sda_q;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_ADDR: if (byte_done) begin
                            bit_cnt <= '0;
                            rw_q    <= shreg[0];
                            sda_oe  <= addr_hit;
                        end
                        ST_INSTR: if (byte_done) begin
                            bit_cnt    <= '0;
                            sda_oe     <= 1'b1;
                            instr_stb  <= 1'b1;
                            instr_sel  <= shreg[7];
                            instr_mid  <= shreg[6];
                            instr_shdn <= shreg[5];
                            instr_o1   <= shreg[4];
                            instr_o2   <= shreg[3];
                        end
                        ST_DATA: if (byte_done) begin
                            bit_cnt  <= '0;
                            sda_oe   <= 1'b1;
                            data_stb <= 1'b1;
                            data_val <= shreg;
                            data_sel <= instr_sel;
                        end
                        ST_ADDR_ACK: begin
                            if (rw_q) begin
                                tx     <= tx_src;
                                sda_oe <= ~tx_src[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        ST_INSTR_ACK, ST_DATA_ACK: sda_oe <= 1'b0;
                        ST_RD_BYTE: begin
                            if (byte_done) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                        ST_RD_ACK: begin
                            if (master_ack) begin
                                tx     <= tx_src;
                                sda_oe <= ~tx_src[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pot_i2c_checker.sv
module pot_i2c_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_q,
    input logic scl_fall,
    input logic instr_stb,
    input logic instr_sel,
    input logic data_stb,
    input logic data_sel
);
    // R9: drive turns on only one cycle after a synchronized SCL fall
    a_r9_oe_rise_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R9: drive never moves while SCL stays high
    a_r9_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q)) |-> $stable(sda_oe));

    // R3: one strobe per instruction byte
    a_r3_instr_single: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |=> !instr_stb);

    // R4: one strobe per data byte
    a_r4_data_single: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> !data_stb);

    // R4: data goes to the instruction's channel
    a_r4_data_channel: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> (data_sel == instr_sel));
endmodule

bind pot_i2c_slave pot_i2c_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_q    (scl_q),
    .scl_fall (scl_fall),
    .instr_stb(instr_stb),
    .instr_sel(instr_sel),
    .data_stb (data_stb),
    .data_sel (data_sel)
);

// File: tb/pot_i2c_slave_test.sv
module pot_i2c_slave_test;
    localparam int Q = 4;  // system clocks per SCL quarter period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [7:0] reg0 = 8'h96;
    logic [7:0] reg1 = 8'h69;
    logic       sda_oe, instr_stb, instr_sel, instr_mid, instr_shdn, instr_o1, instr_o2;
    logic       data_stb, data_sel;
    logic [7:0] data_val;
    logic       sda_bus;

    int n_cmp = 0;
    int n_bad = 0;
    int n_instr = 0;
    int n_data = 0;
    logic [4:0] cap_instr = '0;
    logic [7:0] cap_val = '0;
    logic       cap_sel = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    pot_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap(strap),
        .chan0_val(reg0), .chan1_val(reg1), .sda_oe(sda_oe),
        .instr_stb(instr_stb), .instr_sel(instr_sel), .instr_mid(instr_mid),
        .instr_shdn(instr_shdn), .instr_o1(instr_o1), .instr_o2(instr_o2),
        .data_stb(data_stb), .data_val(data_val), .data_sel(data_sel)
    );

    // Strobe capture and a simple register block model
    always @(negedge clk) begin
        if (instr_stb) begin
            n_instr = n_instr + 1;
            cap_instr = {instr_sel, instr_mid, instr_shdn, instr_o1, instr_o2};
        end
        if (data_stb) begin
            n_data = n_data + 1;
            cap_val = data_val;
            cap_sel = data_sel;
            if (data_sel) reg1 = data_val;
            else          reg0 = data_val;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic wr_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        wr_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = !sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            v[i] = sda_bus; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
        return {5'b01011, s, rd};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int ci, cd;

        tick(6);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        chk(!instr_stb && !data_stb, "R1", "strobes after reset", {instr_stb, data_stb}, 0);
        rst_n = 1'b1;
        tick(4);

        // R1: read before any instruction returns channel 0
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b1), ack);
        chk(ack, "R1", "read address ack", ack, 1);
        rd_byte(1'b0, v);
        chk(v == 8'h96, "R1", "default channel read", v, 8'h96);
        bus_stop();

        // R2: address sweep against every strap setting
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 0; a < 4; a++) begin
                ci = n_instr;
                bus_start();
                wr_byte(addr_byte(2'(a), 1'b0), ack);
                chk(ack == (a == s), "R2", "address ack", ack, (a == s));
                if (a != s) begin
                    wr_byte(8'hFF, ack);
                    chk(!ack && n_instr == ci, "R2", "unaddressed slave silent",
                        {ack, 8'(n_instr - ci)}, 0);
                end
                bus_stop();
            end
        end
        strap = 2'b10;

        // R3: every combination of instruction fields, low bits varied
        for (int k = 0; k < 32; k++) begin
            logic [7:0] ib;
            ib = {5'(k), 3'(k) ^ 3'b101};
            ci = n_instr;
            bus_start();
            wr_byte(addr_byte(2'b10, 1'b0), ack);
            wr_byte(ib, ack);
            bus_stop();
            chk(ack && n_instr == ci + 1 && cap_instr == ib[7:3], "R3",
                "instruction fields", {ack, 4'(n_instr - ci), 3'b0, cap_instr},
                {1'b1, 4'd1, 3'b0, ib[7:3]});
        end

        // R4: data bytes under one instruction
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b0), ack);
        wr_byte(8'h80, ack);
        foreach (v[i]) ;
        cd = n_data;
        wr_byte(8'h3C, ack);
        chk(ack && n_data == cd + 1 && cap_val == 8'h3C && cap_sel, "R4", "data 3C ch1",
            {ack, cap_sel, cap_val}, {1'b1, 1'b1, 8'h3C});
        wr_byte(8'hA5, ack);
        chk(ack && n_data == cd + 2 && cap_val == 8'hA5 && cap_sel, "R4", "data A5 ch1",
            {ack, cap_sel, cap_val}, {1'b1, 1'b1, 8'hA5});
        bus_stop();
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b0), ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h5A, ack);
        chk(ack && cap_val == 8'h5A && !cap_sel, "R4", "data 5A ch0",
            {ack, cap_sel, cap_val}, {1'b1, 1'b0, 8'h5A});
        bus_stop();
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b0), ack);
        wr_byte(8'h9F, ack);
        wr_byte(8'hC3, ack);
        chk(ack && cap_val == 8'hC3 && cap_sel, "R4", "data C3 ch1",
            {ack, cap_sel, cap_val}, {1'b1, 1'b1, 8'hC3});
        bus_stop();

        // R5 and R6: read, repeat on ack, release on nack
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b1), ack);
        rd_byte(1'b1, v);
        chk(v == 8'hC3, "R5", "read selected channel", v, 8'hC3);
        rd_byte(1'b1, v);
        chk(v == 8'hC3, "R6", "repeat after ack 1", v, 8'hC3);
        rd_byte(1'b0, v);
        chk(v == 8'hC3, "R6", "repeat after ack 2", v, 8'hC3);
        rd_byte(1'b0, v);
        chk(v == 8'hFF, "R6", "released after nack", v, 8'hFF);
        bus_stop();

        // R7: select channel then repeated start and read
        ci = n_instr; cd = n_data;
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b0), ack);
        wr_byte(8'h00, ack);
        bus_rstart();
        wr_byte(addr_byte(2'b10, 1'b1), ack);
        chk(ack, "R7", "read address after repeated start", ack, 1);
        rd_byte(1'b0, v);
        bus_stop();
        chk(v == 8'h5A, "R7", "read after repeated start", v, 8'h5A);
        chk(n_instr == ci + 1 && n_data == cd, "R7", "strobe counts",
            {8'(n_instr - ci), 8'(n_data - cd)}, 16'h0100);

        // R8: abort mid data byte with stop
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b0), ack);
        wr_byte(8'h80, ack);
        cd = n_data;
        wr_bits(8'hAA, 4);
        bus_stop();
        chk(n_data == cd, "R8", "no strobe on partial data", n_data - cd, 0);
        // R8: abort mid instruction byte with stop
        ci = n_instr;
        bus_start();
        wr_byte(addr_byte(2'b10, 1'b0), ack);
        wr_bits(8'h00, 5);
        bus_stop();
        chk(n_instr == ci, "R8", "no strobe on partial instruction", n_instr - ci, 0);
        // R8: start mid address byte restarts address phase
        bus_start();
        wr_bits(addr_byte(2'b10, 1'b0), 3);
        bus_rstart();
        wr_byte(addr_byte(2'b10, 1'b1), ack);
        chk(ack, "R8", "address after mid-byte start", ack, 1);
        rd_byte(1'b0, v);
        bus_stop();
        chk(v == 8'hC3, "R8", "channel kept after aborts", v, 8'hC3);

        summary();
        $finish;
    end
endmodule